// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transmitter

This block turns parallel audio words into a serial bit stream framed by a frame sync. An external or separately generated bit clock and frame sync arrive as plain inputs. The block samples them with its own system clock, so the system clock must run several times faster than the bit clock. A drive edge of the bit clock is detected, and every drive edge advances the serial line by one bit.

A frame holds one phase, or two phases back to back. Each phase has its own word length and its own word count. Software places a word in the holding register with a write strobe. The holding register is copied into the shifter at the start of every word. If no new word has been written by then, the last word is sent again. The data-delay field sets the alignment. With a delay of one bit the data follows the sync. With a delay of zero the first bit shares its bit clock with the sync. A frame sync that arrives while a frame is in progress either restarts the frame and raises an error flag, or it is ignored, as the configuration selects.

Top module: `sat_tx`

## Requirements
- R1: The word-length codes in the configuration word give 0=8, 1=12, 2=16, 3=20, 4=24 and 5=32 bits; codes 6 and 7 also give 32. Each word sends bits [len-1:0] of the held word, most significant first. Configuration bits [4:0], 15, 19 and 20 are reserved and must be zero.
- R2: Phase 1 takes its word length from cfg_i[7:5] and its word count minus one from cfg_i[14:8]. Phase 1 sends exactly count words, with no gaps between them.
- R3: When cfg_i[31] is set, phase 2 starts on the drive edge after the last bit of phase 1. It uses the word length in cfg_i[23:21] and the word count minus one in cfg_i[30:24].
- R4: The data delay in cfg_i[17:16] is the number of drive edges between the sync edge and the first data bit. A delay of 0 puts the first bit on the sync edge itself; delays of 1 and 2 are supported.
- R5: When clk_pol_i=1, data changes after rising edges of bclk_i. When clk_pol_i=0, data changes after falling edges. sd_o changes at no other time while the block is enabled.
- R6: When fs_pol_i=0 the frame sync is active high. When fs_pol_i=1 it is active low. A frame starts at the drive edge where the sync is first seen active.
- R7: When cfg_i[18] is set, a sync edge inside a frame is ignored. The frame continues unchanged and sync_err_o stays low.
- R8: When cfg_i[18] is clear, a sync edge inside a frame sets sync_err_o and restarts the frame. sync_err_o stays set until the transmitter is disabled. A sync edge on the drive edge right after the last bit of a frame is a legal new frame.
- R9: While tx_en_i is low, sd_o is 0, sync_err_o is cleared and no bits are shifted or words loaded.
- R10: If no word is written between two loads, the held word is sent again. A word written during a frame is used from the next word boundary on.
- R11: rdy_o pulses high for one system clock each time the holding register is copied into the shifter, once per word.
- R12: Outside a frame, including the drive edges after its last bit, sd_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable; low holds the transmitter in reset |
| cfg_i | input | 32 | Frame configuration word |
| clk_pol_i | input | 1 | 1: drive on rising bit-clock edge, 0: on falling edge |
| fs_pol_i | input | 1 | 1: frame sync active low, 0: active high |
| data_i | input | DW | Word for the holding register |
| wr_i | input | 1 | Write strobe for the holding register |
| bclk_i | input | 1 | Bit clock |
| fs_i | input | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| rdy_o | output | 1 | Holding register copied into the shifter |
| sync_err_o | output | 1 | Unexpected frame sync seen |

## Verification
The bench builds the block with DW=32, its default. This makes every word-length code reachable, including the full 32-bit word, where the most significant bit of the holding register is sent first. With a bit period of eight system clocks, frames of over a hundred bits fit in a short run. This allows a phase with three 20-bit words followed by a phase with two 24-bit words, and 32-bit words with a two-bit delay. The configuration table covers both clock polarities and both sync polarities, across every delay the requirements name.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_SHIFT} sat_st_e;

  localparam int CFG_W = 32;
  localparam int FL_W  = 7;
  localparam int WL_W  = 6;

  function automatic logic [WL_W-1:0] wlen(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd12;
      3'd2:    return 6'd16;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/sat_edge.sv
module sat_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic clk_pol_i,
  input  logic fs_pol_i,
  output logic tick_o,
  output logic fs_act_o
);
  logic b1_q, b2_q, f1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b1_q <= 1'b0;
      b2_q <= 1'b0;
      f1_q <= 1'b0;
    end else begin
      b1_q <= bclk_i;
      b2_q <= b1_q;
      f1_q <= fs_i;
    end
  end

  assign tick_o   = clk_pol_i ? (b1_q & ~b2_q) : (~b1_q & b2_q);
  assign fs_act_o = f1_q ^ fs_pol_i;
endmodule

// File: rtl/sat_hold.sv
module sat_hold #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] hold_o
);
  // never cleared on load: an underrun resends the last word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_o <= '0;
    else if (wr_i) hold_o <= data_i;
  end
endmodule

// File: rtl/sat_seq.sv
module sat_seq
  import sat_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            fs_act_i,
  input  logic [2:0]      wc1_i,
  input  logic [FL_W-1:0] fl1_i,
  input  logic [2:0]      wc2_i,
  input  logic [FL_W-1:0] fl2_i,
  input  logic            dual_i,
  input  logic [1:0]      dly_i,
  input  logic            ign_i,
  input  logic [DW-1:0]   hold_i,
  output logic            sd_o,
  output logic            ld_o,
  output logic            err_o
);
  sat_st_e         st_q;
  logic [1:0]      dcnt_q;
  logic            ph_q;
  logic [FL_W-1:0] wcnt_q;
  logic [WL_W-1:0] bidx_q;
  logic [DW-1:0]   sh_q;
  logic            fs_prev_q;

  logic [WL_W-1:0] wl1, wl2, wl_cur, wl_ld;
  logic [FL_W-1:0] fl_cur;
  logic fs_edge, busy, last_bit, last_word, last_phase, frame_end, restart;

  assign wl1        = wlen(wc1_i);
  assign wl2        = wlen(wc2_i);
  assign wl_cur     = ph_q ? wl2 : wl1;
  assign fl_cur     = ph_q ? fl2_i : fl1_i;
  assign fs_edge    = tick_i & fs_act_i & ~fs_prev_q;
  assign busy       = (st_q != ST_IDLE);
  assign last_bit   = (bidx_q == '0);
  assign last_word  = (wcnt_q == fl_cur);
  assign last_phase = ~dual_i | ph_q;
  assign frame_end  = (st_q == ST_SHIFT) & last_bit & last_word & last_phase;
  assign restart    = fs_edge & (~busy | frame_end | ~ign_i);

  always_comb begin
    if (restart)                               wl_ld = wl1;
    else if (st_q == ST_SHIFT && last_word)    wl_ld = wl2;
    else                                       wl_ld = wl_cur;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      dcnt_q    <= '0;
      ph_q      <= 1'b0;
      wcnt_q    <= '0;
      bidx_q    <= '0;
      sh_q      <= '0;
      fs_prev_q <= 1'b0;
      sd_o      <= 1'b0;
      ld_o      <= 1'b0;
      err_o     <= 1'b0;
    end else if (!en_i) begin
      st_q      <= ST_IDLE;
      fs_prev_q <= 1'b0;
      sd_o      <= 1'b0;
      ld_o      <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      ld_o <= 1'b0;
      if (tick_i) begin
        fs_prev_q <= fs_act_i;
        if (restart) begin
          if (busy && !frame_end) err_o <= 1'b1;
          ph_q   <= 1'b0;
          wcnt_q <= '0;
          if (dly_i == 2'd0) begin
            st_q   <= ST_SHIFT;
            sh_q   <= hold_i;
            bidx_q <= wl_ld - 6'd1;
            sd_o   <= hold_i[wl_ld-6'd1];
            ld_o   <= 1'b1;
          end else begin
            st_q   <= ST_DLY;
            dcnt_q <= dly_i - 2'd1;
            sd_o   <= 1'b0;
          end
        end else begin
          case (st_q)
            ST_IDLE: sd_o <= 1'b0;
            ST_DLY: begin
              if (dcnt_q == 2'd0) begin
                st_q   <= ST_SHIFT;
                sh_q   <= hold_i;
                bidx_q <= wl_ld - 6'd1;
                sd_o   <= hold_i[wl_ld-6'd1];
                ld_o   <= 1'b1;
              end else begin
                dcnt_q <= dcnt_q - 2'd1;
              end
            end
            default: begin
              if (!last_bit) begin
                bidx_q <= bidx_q - 6'd1;
                sd_o   <= sh_q[bidx_q-6'd1];
              end else if (!last_phase || !last_word) begin
                if (last_word) begin
                  ph_q   <= 1'b1;
                  wcnt_q <= '0;
                end else begin
                  wcnt_q <= wcnt_q + 7'd1;
                end
                sh_q   <= hold_i;
                bidx_q <= wl_ld - 6'd1;
                sd_o   <= hold_i[wl_ld-6'd1];
                ld_o   <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
                sd_o <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sat_tx.sv
module sat_tx
  import sat_pkg::*;
#(
  parameter int DW = 32  // must hold the longest word (32 bits)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic [31:0]   cfg_i,
  input  logic          clk_pol_i,
  input  logic          fs_pol_i,
  input  logic [DW-1:0] data_i,
  input  logic          wr_i,
  input  logic          bclk_i,
  input  logic          fs_i,
  output logic          sd_o,
  output logic          rdy_o,
  output logic          sync_err_o
);
  logic          tick, fs_act;
  logic [DW-1:0] hold;

  sat_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_i   (bclk_i),
    .fs_i     (fs_i),
    .clk_pol_i(clk_pol_i),
    .fs_pol_i (fs_pol_i),
    .tick_o   (tick),
    .fs_act_o (fs_act)
  );

  sat_hold #(.DW(DW)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_i),
    .data_i(data_i),
    .hold_o(hold)
  );

  sat_seq #(.DW(DW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tx_en_i),
    .tick_i  (tick),
    .fs_act_i(fs_act),
    .wc1_i   (cfg_i[7:5]),
    .fl1_i   (cfg_i[14:8]),
    .wc2_i   (cfg_i[23:21]),
    .fl2_i   (cfg_i[30:24]),
    .dual_i  (cfg_i[31]),
    .dly_i   (cfg_i[17:16]),
    .ign_i   (cfg_i[18]),
    .hold_i  (hold),
    .sd_o    (sd_o),
    .ld_o    (rdy_o),
    .err_o   (sync_err_o)
  );
endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_en_i,
  input logic [31:0] cfg_i,
  input logic        sd_o,
  input logic        rdy_o,
  input logic        sync_err_o,
  input logic        tick_i
);
  AST_CFG_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |-> (cfg_i[4:0] == 5'd0 && !cfg_i[15] && cfg_i[20:19] == 2'd0)); // R1

  AST_SD_ON_DRIVE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> ($past(tick_i) || !$past(tx_en_i))); // R5

  AST_IGNORE_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> !$past(cfg_i[18])); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_err_o && tx_en_i) |=> sync_err_o); // R8

  AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> (!sd_o && !sync_err_o && !rdy_o)); // R9

  AST_RDY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o); // R11
endmodule

bind sat_tx sat_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_en_i   (tx_en_i),
  .cfg_i     (cfg_i),
  .sd_o      (sd_o),
  .rdy_o     (rdy_o),
  .sync_err_o(sync_err_o),
  .tick_i    (tick)
);

// File: tb/sim_sat_tx.sv
`timescale 1ns/1ps
module sim_sat_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_en_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic        clk_pol_i = 1'b1;
  logic        fs_pol_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        wr_i = 1'b0;
  logic        bclk_i = 1'b0;
  logic        fs_i = 1'b0;
  logic        sd_o, rdy_o, sync_err_o;

  int checks = 0;
  int fails = 0;
  int rdy_cnt = 0;

  always #5 clk_i = ~clk_i;

  sat_tx u0 (.*);

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] data;
    logic        cp;
    logic        fp;
  } vec_t;

  function automatic logic [31:0] mkcfg(int w1, int f1, int dly, int ign, int w2, int f2, int dual);
    logic [31:0] c = '0;
    c[7:5]   = w1[2:0];
    c[14:8]  = f1[6:0];
    c[17:16] = dly[1:0];
    c[18]    = ign[0];
    c[23:21] = w2[2:0];
    c[30:24] = f2[6:0];
    c[31]    = dual[0];
    return c;
  endfunction

  localparam vec_t VT [5] = '{
    '{mkcfg(2, 1, 1, 0, 0, 0, 0), 32'h0000_A5C3, 1'b1, 1'b0},
    '{mkcfg(0, 0, 0, 0, 1, 0, 1), 32'h0000_0F3C, 1'b0, 1'b1},
    '{mkcfg(5, 0, 2, 0, 0, 0, 0), 32'h8123_4567, 1'b1, 1'b1},
    '{mkcfg(3, 2, 1, 0, 4, 1, 1), 32'h00C3_5A69, 1'b0, 1'b0},
    '{mkcfg(1, 3, 0, 0, 0, 0, 0), 32'h0000_0ABC, 1'b1, 1'b0}
  };

  function automatic int wl(logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int frame_bits(logic [31:0] c);
    int n = (int'(c[14:8]) + 1) * wl(c[7:5]);
    if (c[31]) n += (int'(c[30:24]) + 1) * wl(c[23:21]);
    return n;
  endfunction

  function automatic logic exp_bit(logic [31:0] c, logic [31:0] d, int k);
    int w1 = wl(c[7:5]);
    int w2 = wl(c[23:21]);
    int n1 = (int'(c[14:8]) + 1) * w1;
    int j  = k - int'(c[17:16]);
    if (j < 0 || j >= frame_bits(c)) return 1'b0;
    if (j < n1) return d[w1 - 1 - (j % w1)];
    j -= n1;
    return d[w2 - 1 - (j % w2)];
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_period(input logic act, output logic s);
    @(negedge clk_i);
    bclk_i = clk_pol_i;
    fs_i   = act ^ fs_pol_i;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (rdy_o) rdy_cnt++;
    end
    s = sd_o;
    bclk_i = ~clk_pol_i;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (rdy_o) rdy_cnt++;
    end
  endtask

  task automatic write_word(input logic [31:0] d);
    @(negedge clk_i);
    data_i = d;
    wr_i   = 1'b1;
    @(negedge clk_i);
    wr_i   = 1'b0;
  endtask

  task automatic setup(input logic [31:0] c, input logic cp, input logic fp, input logic [31:0] d);
    @(negedge clk_i);
    tx_en_i   = 1'b0;
    cfg_i     = c;
    clk_pol_i = cp;
    fs_pol_i  = fp;
    bclk_i    = ~cp;
    fs_i      = fp;
    write_word(d);
    repeat (3) @(negedge clk_i);
    tx_en_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rdy_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic s;
    logic [31:0] got, want;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk(sd_o == 1'b0, "R9 reset sd", 64'(sd_o), 0);
    chk(rdy_o == 1'b0, "R11 reset rdy", 64'(rdy_o), 0);
    chk(sync_err_o == 1'b0, "R9 reset err", 64'(sync_err_o), 0);
    rst_ni = 1'b1;

    // table: R1 R2 R3 R4 R5 R6 R10 R12
    for (int v = 0; v < 5; v++) begin
      int n, bad, first;
      logic a, e;
      setup(VT[v].cfg, VT[v].cp, VT[v].fp, VT[v].data);
      n = frame_bits(VT[v].cfg) + int'(VT[v].cfg[17:16]) + 3;
      bad = 0; first = -1; a = 0; e = 0;
      for (int k = 0; k < n; k++) begin
        bit_period(k == 0, s);
        if (s !== exp_bit(VT[v].cfg, VT[v].data, k) && first < 0) begin
          bad = 1; first = k; a = s; e = exp_bit(VT[v].cfg, VT[v].data, k);
        end
      end
      if (bad != 0) $display("vector %0d first mismatch at bit %0d", v, first);
      chk(bad == 0, "R1/R2/R3/R4/R5/R6/R12 stream", 64'(a), 64'(e));
      chk(rdy_cnt == int'(VT[v].cfg[14:8]) + 1 + (VT[v].cfg[31] ? int'(VT[v].cfg[30:24]) + 1 : 0),
          "R11 rdy per word", 64'(rdy_cnt), 64'(int'(VT[v].cfg[14:8]) + 1));
      chk(sync_err_o == 1'b0, "R8 no error on clean frame", 64'(sync_err_o), 0);
    end

    // R10: word written mid-frame used at next word, then repeated on underrun
    setup(mkcfg(0, 1, 0, 0, 0, 0, 0), 1'b1, 1'b0, 32'h5A);
    got = '0;
    for (int k = 0; k < 16; k++) begin
      bit_period(k == 0, s);
      got = {got[30:0], s};
      if (k == 2) write_word(32'hC3);
    end
    chk(got[15:0] == 16'h5AC3, "R10 new word at boundary", 64'(got[15:0]), 64'h5AC3);
    got = '0;
    for (int k = 0; k < 17; k++) begin
      bit_period(k == 0, s);
      if (k < 16) got = {got[30:0], s};
    end
    chk(got[15:0] == 16'hC3C3, "R10 underrun repeats", 64'(got[15:0]), 64'hC3C3);
    chk(s == 1'b0, "R12 idle after frame", 64'(s), 0);

    // R7: mid-frame sync ignored
    setup(mkcfg(0, 0, 0, 1, 0, 0, 0), 1'b1, 1'b0, 32'h0F);
    got = '0;
    for (int k = 0; k < 9; k++) begin
      bit_period(k == 0 || k == 3, s);
      got = {got[30:0], s};
    end
    want = 32'h01E;
    chk(got[8:0] == want[8:0], "R7 ignored sync stream", 64'(got[8:0]), 64'(want[8:0]));
    chk(sync_err_o == 1'b0, "R7 no error", 64'(sync_err_o), 0);

    // R8: mid-frame sync restarts and flags
    setup(mkcfg(0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, 32'h0F);
    got = '0;
    for (int k = 0; k < 12; k++) begin
      bit_period(k == 0 || k == 3, s);
      got = {got[30:0], s};
    end
    want = 32'h01E;  // 000 00001111 0
    chk(got[11:0] == want[11:0], "R8 restart stream", 64'(got[11:0]), 64'(want[11:0]));
    chk(sync_err_o == 1'b1, "R8 error set", 64'(sync_err_o), 1);
    @(negedge clk_i);
    tx_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(sync_err_o == 1'b0, "R9 error cleared on disable", 64'(sync_err_o), 0);

    // R8: back-to-back frames, sync right after last bit is legal
    setup(mkcfg(0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, 32'hA5);
    got = '0;
    for (int k = 0; k < 17; k++) begin
      bit_period(k == 0 || k == 8, s);
      if (k < 16) got = {got[30:0], s};
    end
    chk(got[15:0] == 16'hA5A5 && sync_err_o == 1'b0, "R8 back-to-back legal",
        64'({sync_err_o, got[15:0]}), 64'h0A5A5);

    // R9: disable mid-frame stops shifting and loading
    setup(mkcfg(2, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, 32'hFFFF);
    for (int k = 0; k < 3; k++) bit_period(k == 0, s);
    @(negedge clk_i);
    tx_en_i = 1'b0;
    rdy_cnt = 0;
    got = '0;
    for (int k = 0; k < 4; k++) begin
      bit_period(k == 1, s);
      got = {got[30:0], s};
    end
    chk(got[3:0] == 4'h0 && rdy_cnt == 0, "R9 held in reset", 64'({rdy_cnt[3:0], got[3:0]}), 0);
    @(negedge clk_i);
    tx_en_i = 1'b1;
    got = '0;
    for (int k = 0; k < 4; k++) begin
      bit_period(1'b0, s);
      got = {got[30:0], s};
    end
    chk(got[3:0] == 4'h0, "R12 idle without sync", 64'(got[3:0]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule